// File: doc/BRIEF.md
# Video Transmitter Register Loader over I2C

This block programs an external video transmitter chip over a two-wire I2C bus, using nothing but register writes. After reset it plays a short, fixed power-up script of five register writes. Until the last of them has finished on the wire, it holds its ready output low, and the display pipeline behind it stays in reset on that signal.

Once the script is done, software can send further single writes through a 32-bit command word. The word carries a start flag, a register number and a data byte. The hardware drops the start flag when the write has finished on the bus, so software can poll for completion.

Both bus lines are open-drain. Each line has an output that is always low, a tristate enable (1 means released, 0 means pulled low) and an input that reads the line level. SCL timing comes from the system clock through a quarter-period divider, `QTR_DIV` system clocks per quarter of an SCL period. The loader is built only when the parameters select the digital video output and turn the serial link on. Otherwise the ready output is tied high and both lines stay released.

Top module: `vtx_cfg_seq`

## Requirements
- R1: While reset is asserted, `scl_t` and `sda_t` are 1, `cfg_done`, `bus_err` and `cmd_rdata` are 0. `scl_o` and `sda_o` are 0 at all times.
- R2: After reset the bus carries five write frames in this order (register, data): (0x49,0xC0), (0x21,0x09), (0x33,0x08), (0x34,0x16), (0x36,0x60). Every frame opens with the address byte {SLAVE_ADDR, 0}, which is 0xEC for the default 0x76.
- R3: `cfg_done` stays 0 until the STOP of the fifth power-up frame has appeared on the bus. After that it rises and stays 1 until the next reset.
- R4: A frame is START, address byte, acknowledge, register byte, acknowledge, data byte, acknowledge, STOP. Bytes go out most significant bit first, and the block releases SDA in every acknowledge clock. Between START and STOP, SDA changes only while SCL is low.
- R5: Command word layout: bit 31 is start, bits 15:8 are the register, bits 7:0 are the data, and bits 30:16 always read as 0. A write with bit 31 clear stores the fields and puts no frame on the bus.
- R6: Writing the command word with bit 31 set sends one frame. Bit 31 reads 1 until that frame's STOP has been driven, and then reads 0.
- R7: A start written while the power-up script is still running is kept. Its frame goes out right after the fifth script frame.
- R8: When SDA reads high during an acknowledge clock, the frame ends at once with a STOP and `bus_err` is set. `bus_err` then stays 1 until reset. The loader carries on with the next script entry, or clears the start bit if the frame was a host write.
- R9: Every low phase of SCL lasts exactly 2*QTR_DIV system clocks.
- R10: A command word write that arrives while bit 31 is still set is ignored. The stored register and data fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | One-cycle write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command word read-back |
| cfg_done | output | 1 | High once the power-up script has finished; the downstream pipeline stays in reset while it is low |
| bus_err | output | 1 | Sticky flag: a missing acknowledge was seen |
| scl_o | output | 1 | SCL output level (always 0) |
| scl_i | input | 1 | SCL line level |
| scl_t | output | 1 | SCL tristate enable, 1 releases the line |
| sda_o | output | 1 | SDA output level (always 0) |
| sda_i | input | 1 | SDA line level |
| sda_t | output | 1 | SDA tristate enable, 1 releases the line |

## Verification
The assertions assume that the bus has no other master and that nobody stretches the clock. A released SCL may read either level, but an SCL the block pulls low must read low. They also assume that `cmd_wr` lasts a single cycle. The bench keeps to this. It models the lines as pull-ups wired with the tristate enables, drives SCL from nothing but the block, and has its target device touch SDA only while SCL is low. Command writes are one-cycle strobes issued at the falling edge. A missing acknowledge is set up by telling the target model to stay silent after one chosen register byte.

// File: rtl/vtx_cfg_pkg.sv
package vtx_cfg_pkg;

  typedef struct packed {
    logic [7:0] reg_addr;
    logic [7:0] value;
  } reg_wr_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_BITS  = 2'd2,
    PH_STOP  = 2'd3
  } phase_t;

  localparam int unsigned BOOT_LEN = 5;

  // Power-up script: register / value pairs, played in index order.
  function automatic reg_wr_t boot_entry(input logic [2:0] idx);
    reg_wr_t e;
    case (idx)
      3'd0:    e = '{reg_addr: 8'h49, value: 8'hC0};
      3'd1:    e = '{reg_addr: 8'h21, value: 8'h09};
      3'd2:    e = '{reg_addr: 8'h33, value: 8'h08};
      3'd3:    e = '{reg_addr: 8'h34, value: 8'h16};
      default: e = '{reg_addr: 8'h36, value: 8'h60};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/vtx_qtr_tick.sv
module vtx_qtr_tick #(
  parameter int unsigned QTR_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/vtx_wr_engine.sv
module vtx_wr_engine
  import vtx_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h76
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    go,
  input  reg_wr_t wr,
  input  logic    sda_i,
  output logic    busy,
  output logic    done,
  output logic    nack,
  output logic    scl_t,
  output logic    sda_t
);
  localparam int unsigned CELL       = 9;
  localparam int unsigned FRAME_BITS = 3 * CELL;
  localparam int unsigned IW         = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

  phase_t                st_q, st_d;
  logic [1:0]            q_q, q_d;
  logic [IW-1:0]         idx_q, idx_d;
  logic [FRAME_BITS-1:0] frm_q, frm_d;
  logic                  nack_q, nack_d;
  logic                  done_q, done_d;
  logic                  ack_cell;
  logic                  cur_bit;

  always_comb begin
    ack_cell = ((idx_q == IW'(CELL - 1)) || (idx_q == IW'(2 * CELL - 1)) ||
                (idx_q == LAST_IDX));
    cur_bit  = frm_q[LAST_IDX - idx_q];
  end

  // next-state
  always_comb begin
    st_d   = st_q;
    q_d    = q_q;
    idx_d  = idx_q;
    frm_d  = frm_q;
    nack_d = nack_q;
    done_d = 1'b0;
    case (st_q)
      PH_IDLE: if (go) begin
        st_d   = PH_START;
        q_d    = 2'd0;
        nack_d = 1'b0;
        frm_d  = {SLAVE_ADDR, 1'b0, 1'b1, wr.reg_addr, 1'b1, wr.value, 1'b1};
      end
      PH_START: if (tick) begin
        q_d = q_q + 2'd1;
        if (q_q == 2'd3) begin
          st_d  = PH_BITS;
          idx_d = '0;
        end
      end
      PH_BITS: if (tick) begin
        q_d = q_q + 2'd1;
        if (q_q == 2'd3) begin
          if (ack_cell && sda_i) begin
            nack_d = 1'b1;
            st_d   = PH_STOP;
          end else if (idx_q == LAST_IDX) begin
            st_d = PH_STOP;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: if (tick) begin
        q_d = q_q + 2'd1;
        if (q_q == 2'd3) begin
          st_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      q_q    <= 2'd0;
      idx_q  <= '0;
      frm_q  <= '0;
      nack_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      q_q    <= q_d;
      idx_q  <= idx_d;
      frm_q  <= frm_d;
      nack_q <= nack_d;
      done_q <= done_d;
    end
  end

  // line decode: quarters 0,1 SCL low, 2,3 SCL released
  always_comb begin
    case (st_q)
      PH_IDLE:  begin scl_t = 1'b1;      sda_t = 1'b1;          end
      PH_START: begin scl_t = 1'b1;      sda_t = (q_q < 2'd2);  end
      PH_BITS:  begin scl_t = q_q[1];    sda_t = cur_bit;       end
      default:  begin scl_t = q_q[1];    sda_t = (q_q == 2'd3); end
    endcase
    busy = (st_q != PH_IDLE);
    done = done_q;
    nack = nack_q;
  end

  // R4: inside the bit cells, data is steady while the clock is high
  a_r4_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_BITS && $past(st_q) == PH_BITS && scl_t && $past(scl_t)) |-> $stable(sda_t));

  // R2: every launch from the sequencer lands on an idle engine
  a_r2_go_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st_q == PH_IDLE));

endmodule

// File: rtl/vtx_cfg_ctrl.sv
module vtx_cfg_ctrl
  import vtx_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  input  logic        eng_busy,
  input  logic        eng_done,
  input  logic        eng_nack,
  output logic        go,
  output reg_wr_t     wr,
  output logic        cfg_done,
  output logic        bus_err
);
  localparam logic [2:0] LAST_BOOT = 3'(BOOT_LEN - 1);

  logic [2:0] bidx_q, bidx_d;
  logic       booted_q, booted_d;
  logic       infl_q, infl_d;
  logic       hstart_q, hstart_d;
  logic [7:0] hreg_q, hreg_d;
  logic [7:0] hdat_q, hdat_d;
  logic       err_q, err_d;

  always_comb begin
    go = !infl_q && !eng_busy && (!booted_q || hstart_q);
    wr = booted_q ? '{reg_addr: hreg_q, value: hdat_q} : boot_entry(bidx_q);
  end

  // next-state
  always_comb begin
    bidx_d   = bidx_q;
    booted_d = booted_q;
    infl_d   = infl_q;
    hstart_d = hstart_q;
    hreg_d   = hreg_q;
    hdat_d   = hdat_q;
    err_d    = err_q;
    if (go) infl_d = 1'b1;
    if (eng_done) begin
      infl_d = 1'b0;
      if (eng_nack) err_d = 1'b1;
      if (!booted_q) begin
        bidx_d = bidx_q + 3'd1;
        if (bidx_q == LAST_BOOT) booted_d = 1'b1;
      end else begin
        hstart_d = 1'b0;
      end
    end
    if (cmd_wr && !hstart_q) begin
      hstart_d = cmd_wdata[31];
      hreg_d   = cmd_wdata[15:8];
      hdat_d   = cmd_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bidx_q   <= 3'd0;
      booted_q <= 1'b0;
      infl_q   <= 1'b0;
      hstart_q <= 1'b0;
      hreg_q   <= 8'd0;
      hdat_q   <= 8'd0;
      err_q    <= 1'b0;
    end else begin
      bidx_q   <= bidx_d;
      booted_q <= booted_d;
      infl_q   <= infl_d;
      hstart_q <= hstart_d;
      hreg_q   <= hreg_d;
      hdat_q   <= hdat_d;
      err_q    <= err_d;
    end
  end

  always_comb begin
    cmd_rdata = {hstart_q, 15'd0, hreg_q, hdat_q};
    cfg_done  = booted_q;
    bus_err   = err_q;
  end

  // R3: ready never drops once raised
  a_r3_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);

  // R6: the start flag falls only when the engine reports a finished frame
  a_r6_start_clears_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_rdata[31]) |-> $past(eng_done));

  // R8: error flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> bus_err);

  // R5: reserved bits written as ones never show up on read-back
  a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (cmd_wdata[30:16] != 15'd0)) |=> (cmd_rdata[30:16] == 15'd0));

endmodule

// File: rtl/vtx_cfg_seq.sv
module vtx_cfg_seq
  import vtx_cfg_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR = 7'h76,
  parameter int unsigned QTR_DIV    = 4,
  parameter bit          DVI_MODE   = 1'b1,
  parameter bit          LINK_EN    = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        cfg_done,
  output logic        bus_err,
  output logic        scl_o,
  input  logic        scl_i,
  output logic        scl_t,
  output logic        sda_o,
  input  logic        sda_i,
  output logic        sda_t
);
  assign scl_o = 1'b0;
  assign sda_o = 1'b0;

  generate
    if (DVI_MODE && LINK_EN) begin : g_loader
      logic    tick, go, eng_busy, eng_done, eng_nack;
      reg_wr_t wr;

      vtx_qtr_tick #(.QTR_DIV(QTR_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick));

      vtx_cfg_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .eng_busy(eng_busy), .eng_done(eng_done),
        .eng_nack(eng_nack), .go(go), .wr(wr), .cfg_done(cfg_done),
        .bus_err(bus_err));

      vtx_wr_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .wr(wr),
        .sda_i(sda_i), .busy(eng_busy), .done(eng_done), .nack(eng_nack),
        .scl_t(scl_t), .sda_t(sda_t));

      // R4: a clock line this block pulls low reads low (no other master)
      a_r4_scl_pulled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_t |-> !scl_i);
    end else begin : g_bypass
      assign cmd_rdata = 32'd0;
      assign cfg_done  = 1'b1;
      assign bus_err   = 1'b0;
      assign scl_t     = 1'b1;
      assign sda_t     = 1'b1;
    end
  endgenerate

endmodule

// File: tb/vtx_cfg_seq_test.sv
module vtx_cfg_seq_test;
  localparam int unsigned Q = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_wr;
  logic [31:0] cmd_wdata;
  logic [31:0] cmd_rdata;
  logic        cfg_done, bus_err;
  logic        scl_o, scl_t, sda_o, sda_t;
  logic        scl_line, sda_line;
  logic        slv_drv = 1'b0;

  always #4 clk = ~clk;

  assign scl_line = scl_t ? 1'b1 : scl_o;
  assign sda_line = (sda_t ? 1'b1 : sda_o) & ~slv_drv;

  vtx_cfg_seq #(.QTR_DIV(Q)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .cfg_done(cfg_done), .bus_err(bus_err),
    .scl_o(scl_o), .scl_i(scl_line), .scl_t(scl_t),
    .sda_o(sda_o), .sda_i(sda_line), .sda_t(sda_t));

  int checks = 0;
  int errors = 0;
  bit fin = 1'b0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // scoreboard: {len[1:0], addr, reg, data}
  logic [25:0] exp_q[$];
  string       tag_q[$];

  task automatic push_frame(input logic [7:0] r, input logic [7:0] d,
                            input logic [1:0] len, input string tag);
    exp_q.push_back({len, 8'hEC, r, d});
    tag_q.push_back(tag);
  endtask

  // target model and bus monitor
  bit         nack_en = 1'b0;
  logic [7:0] nack_reg = 8'h00;
  bit         p_scl = 1'b1, p_sda = 1'b1, in_frame = 1'b0, width_bad = 1'b0, od_bad = 1'b0;
  int         nbits = 0, nbytes = 0, low_cnt = 0, frames_seen = 0;
  logic [7:0] cur = 8'h00;
  logic [7:0] got [0:2];

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_o || sda_o) od_bad = 1'b1;
      if (!scl_line) low_cnt++;
      if (scl_line && !p_scl) begin
        if (low_cnt != 2 * Q) width_bad = 1'b1;
        low_cnt = 0;
      end
      if (scl_line && p_scl && p_sda && !sda_line) begin
        in_frame = 1'b1; nbits = 0; nbytes = 0; width_bad = 1'b0;
      end else if (scl_line && p_scl && !p_sda && sda_line && in_frame) begin
        in_frame = 1'b0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", {got[0], got[1], got[2], 8'(nbytes)}, 32'h0);
        end else begin
          logic [25:0] e;
          string t;
          bit ok;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          ok = (nbytes == int'(e[25:24])) && (got[0] == e[23:16]) && (got[1] == e[15:8]) &&
               ((e[25:24] != 2'd3) || (got[2] == e[7:0]));
          chk(ok, t, {6'd0, 2'(nbytes), got[0], got[1], got[2]}, {6'd0, e});
          chk(!width_bad, "R9 SCL low phase width", 32'(width_bad), 32'd0);
          if (frames_seen == 4) chk(cfg_done == 1'b0, "R3 done low at last script STOP", 32'(cfg_done), 32'd0);
        end
        frames_seen++;
      end else if (scl_line && !p_scl && in_frame) begin
        if ((nbits % 9) < 8) cur = {cur[6:0], sda_line};
        else if (nbytes < 3) begin got[nbytes] = cur; nbytes++; end
        nbits++;
      end
      if (!scl_line && p_scl && in_frame) begin
        if ((nbits % 9) == 8)
          slv_drv = !(nack_en && (nbits / 9) == 1 && cur == nack_reg);
        else if ((nbits % 9) == 0 && nbits > 0)
          slv_drv = 1'b0;
      end
      p_scl = scl_line;
      p_sda = (sda_t ? 1'b1 : sda_o) & ~slv_drv;
    end
  end

  task automatic host_write(input logic [31:0] w);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_wdata = 32'h0;
  endtask

  task automatic wait_start_clear();
    for (int i = 0; i < 4000 && cmd_rdata[31]; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_wdata = 32'h0;
    nack_en = 1'b1; nack_reg = 8'h33;
    push_frame(8'h49, 8'hC0, 2'd3, "R2 script entry 0");
    push_frame(8'h21, 8'h09, 2'd3, "R2 script entry 1");
    push_frame(8'h33, 8'h08, 2'd2, "R8 script NACK cut frame");
    push_frame(8'h34, 8'h16, 2'd3, "R8 script continues entry 3");
    push_frame(8'h36, 8'h60, 2'd3, "R2 script entry 4");
    repeat (3) @(negedge clk);
    chk(scl_t && sda_t, "R1 lines released in reset", {30'd0, scl_t, sda_t}, 32'd3);
    chk(!scl_o && !sda_o, "R1 outputs low in reset", {30'd0, scl_o, sda_o}, 32'd0);
    chk(!cfg_done && !bus_err, "R1 flags in reset", {30'd0, cfg_done, bus_err}, 32'd0);
    chk(cmd_rdata == 32'd0, "R1 command word in reset", cmd_rdata, 32'd0);
    rst_n = 1'b1;

    // R7: host request during the script
    repeat (20) @(negedge clk);
    host_write(32'h8000_5A3C);
    push_frame(8'h5A, 8'h3C, 2'd3, "R7 held host frame after script");
    chk(cmd_rdata == 32'h8000_5A3C, "R6 start reads 1 while pending", cmd_rdata, 32'h8000_5A3C);
    chk(cfg_done == 1'b0, "R3 done low during script", 32'(cfg_done), 32'd0);
    for (int i = 0; i < 8000 && !cfg_done; i++) @(negedge clk);
    chk(cfg_done == 1'b1, "R3 done after script", 32'(cfg_done), 32'd1);
    chk(bus_err == 1'b1, "R8 sticky error after NACK", 32'(bus_err), 32'd1);
    wait_start_clear();
    chk(cmd_rdata[31] == 1'b0, "R6 start self-clears", cmd_rdata, 32'h0000_5A3C);
    chk(exp_q.size() == 0 && frames_seen == 6, "R7 host frame on bus before clear",
        32'(frames_seen), 32'd6);

    // R5: reserved bits and start=0
    host_write(32'h7FFF_1234);
    chk(cmd_rdata == 32'h0000_1234, "R5 layout and reserved zero", cmd_rdata, 32'h0000_1234);
    repeat (600) @(negedge clk);
    chk(frames_seen == 6, "R5 no frame without start", 32'(frames_seen), 32'd6);

    // R10: second write while busy is dropped
    host_write(32'h8000_A155);
    push_frame(8'hA1, 8'h55, 2'd3, "R6 host frame A1/55");
    repeat (20) @(negedge clk);
    host_write(32'h8000_B266);
    chk(cmd_rdata == 32'h8000_A155, "R10 write during busy ignored", cmd_rdata, 32'h8000_A155);
    wait_start_clear();
    chk(cmd_rdata == 32'h0000_A155, "R10 fields kept after clear", cmd_rdata, 32'h0000_A155);
    repeat (600) @(negedge clk);
    chk(frames_seen == 7, "R10 single frame only", 32'(frames_seen), 32'd7);

    // R8: NACK on a host write
    nack_reg = 8'hC4;
    host_write(32'h8000_C477);
    push_frame(8'hC4, 8'h77, 2'd2, "R8 host NACK cut frame");
    wait_start_clear();
    chk(cmd_rdata[31] == 1'b0, "R8 start cleared after NACK", cmd_rdata, 32'h0000_C477);
    chk(bus_err == 1'b1, "R8 error still set", 32'(bus_err), 32'd1);

    // R4: edge data patterns
    nack_en = 1'b0;
    host_write(32'h8000_00FF);
    push_frame(8'h00, 8'hFF, 2'd3, "R4 frame 00/FF");
    wait_start_clear();
    host_write(32'h8000_FF00);
    push_frame(8'hFF, 8'h00, 2'd3, "R4 frame FF/00");
    wait_start_clear();
    repeat (100) @(negedge clk);
    chk(frames_seen == 10 && exp_q.size() == 0, "R4 all frames observed", 32'(frames_seen), 32'd10);
    chk(!od_bad, "R1 outputs always low", 32'(od_bad), 32'd0);
    chk(scl_t && sda_t, "R1 lines released when idle", {30'd0, scl_t, sda_t}, 32'd3);

    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule